// File: doc/BRIEF.md
# Triplicated Voting Register Stage

This block is a state register slice hardened against single upsets by building it three times. Each copy, or domain, has its own clock, reset, control inputs and data input, its own next-state logic and its own W-bit register. No register feeds its own logic directly. Each domain holds a private bitwise majority voter over all three registers and uses that voted value as its feedback. The next-state logic is a small accumulator. A load writes the domain's data input. An accumulate adds the data input to the voted state. With neither, the stage holds the voted state.

Each domain drives its own output copy with an enable. A per-domain minority check compares the domain's register with the majority. A copy that disagrees has its enable dropped and its data forced to zero, so downstream logic receives only the healthy copies. Each domain also has a saturating mismatch counter with its own synchronous clear. A status vector shows which copies are currently switched off, and a flag shows when the fault has spread beyond one domain and can no longer be outvoted.

A typical use places the stage where state must survive a particle strike, with the three domains' outputs routed to three separate consumers or pins.

Top module: `tmr_vote_stage`

## Requirements
- R1: While `rst[d]` is high at a rising edge of `clk[d]`, domain d's register takes `RST_VAL` (default 8'h5A) and its error counter becomes 0.
- R2: Each domain has a next-state function with `ld[d]` taking priority. With `ld[d]` set, the next state is `din[d]`. Otherwise, with `acc[d]` set, it is the voted state plus `din[d]` modulo 2^W. With neither set, it is the voted state.
- R3: Suppose exactly one domain's register differs from the other two, and no domain loads or accumulates. After the next edge, that domain holds the majority value and all copies are enabled again.
- R4: `oe[d]` is 1 exactly when domain d's register equals the majority value. When `oe[d]` is 1, `q[d]` carries the register. When `oe[d]` is 0, `q[d]` is 0. Two enabled copies always carry equal data.
- R5: `disabled[d]` is 1 exactly when copy d's output is switched off (`oe[d]` = 0).
- R6: `uncorrectable` is 1 when two or more domains differ from the majority value, and 0 otherwise.
- R7: A domain's error counter rises by exactly one at each edge where that domain differed from the majority just before the edge. Otherwise it keeps its value.
- R8: An error counter that has reached 2^CW-1 (15 by default) stays there while further mismatches occur.
- R9: `clr[d]` clears only domain d's counter at the next edge and takes priority over an increment. The other counters keep their values.
- R10: The majority is formed bit by bit as (a&b)|(a&c)|(b&c). For the three values 8'h11, 8'h22 and 8'h33 it is 8'h33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 3 | Clock, one bit per domain |
| rst | input | 3 | Synchronous active-high reset, one bit per domain |
| ld | input | 3 | Load request, one bit per domain |
| acc | input | 3 | Accumulate request, one bit per domain |
| clr | input | 3 | Synchronous error counter clear, one bit per domain |
| din | input | 3×W | Data input, one W-bit copy per domain |
| q | output | 3×W | Output copy per domain, zero while disabled |
| oe | output | 3 | Output enable per domain |
| err_cnt | output | 3×CW | Saturating mismatch counter per domain |
| disabled | output | 3 | Bit d set while copy d is switched off |
| uncorrectable | output | 1 | Two or more domains differ from the majority |

## Verification
A register corrupted in one domain appears at the ports in the same cycle. That copy's `oe` drops, its `q` goes to zero and its `disabled` bit rises, while the other two copies continue to show the correct value. One edge later the copy is enabled again, and its counter has risen by one. A corruption in two domains raises `uncorrectable` in the same cycle and leaves only the majority copy enabled. Faults are injected at the ports by feeding one or two domains a differing data input under load or accumulate, so every divergence, repair and count is visible one edge after the stimulus.

// File: rtl/tmr_vote_stage.sv
module tmr_vote_stage #(
  parameter int W = 8,
  parameter int CW = 4,
  parameter logic [W-1:0] RST_VAL = W'('h5A)
) (
  input  logic [2:0]          clk,
  input  logic [2:0]          rst,
  input  logic [2:0]          ld,
  input  logic [2:0]          acc,
  input  logic [2:0]          clr,
  input  logic [2:0][W-1:0]   din,
  output logic [2:0][W-1:0]   q,
  output logic [2:0]          oe,
  output logic [2:0][CW-1:0]  err_cnt,
  output logic [2:0]          disabled,
  output logic                uncorrectable
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [2:0][W-1:0] st_all;

  for (genvar d = 0; d < 3; d++) begin : g_dom
    localparam int PA = (d + 1) % 3;
    localparam int PB = (d + 2) % 3;

    logic [W-1:0]  st;
    logic [W-1:0]  vote;
    logic [W-1:0]  nxt;
    logic [CW-1:0] cnt;

    assign vote = (st_all[d] & st_all[PA]) | (st_all[d] & st_all[PB]) |
                  (st_all[PA] & st_all[PB]);

    always_comb begin
      if (ld[d])       nxt = din[d];
      else if (acc[d]) nxt = vote + din[d];
      else             nxt = vote;
    end

    always_ff @(posedge clk[d]) begin
      if (rst[d]) st <= RST_VAL;
      else        st <= nxt;
    end

    always_ff @(posedge clk[d]) begin
      if (rst[d] || clr[d])                 cnt <= '0;
      else if (disabled[d] && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign st_all[d]   = st;
    assign disabled[d] = (st != vote);
    assign oe[d]       = ~disabled[d];
    assign q[d]        = oe[d] ? st : '0;
    assign err_cnt[d]  = cnt;
  end

  assign uncorrectable = (disabled[0] & disabled[1]) |
                         (disabled[0] & disabled[2]) |
                         (disabled[1] & disabled[2]);

endmodule

// File: rtl/tmr_vote_stage_chk.sv
module tmr_vote_stage_chk #(
  parameter int W = 8,
  parameter int CW = 4
) (
  input logic [2:0]          clk,
  input logic [2:0]          rst,
  input logic [2:0]          ld,
  input logic [2:0]          acc,
  input logic [2:0]          clr,
  input logic [2:0][W-1:0]   q,
  input logic [2:0]          oe,
  input logic [2:0][CW-1:0]  err_cnt,
  input logic [2:0]          disabled,
  input logic                uncorrectable
);

  a_r3_single_repaired: assert property (@(posedge clk[0]) disable iff (|rst)
    ($countones(disabled) == 1 && ld == 3'b000 && acc == 3'b000) |=> disabled == 3'b000);

  a_r6_flag_needs_two: assert property (@(posedge clk[0]) disable iff (|rst)
    uncorrectable |-> $countones(oe) <= 1);

  for (genvar d = 0; d < 3; d++) begin : g_chk
    localparam int PN = (d + 1) % 3;

    a_r4_enabled_agree: assert property (@(posedge clk[0]) disable iff (|rst)
      (oe[d] && oe[PN]) |-> q[d] == q[PN]);

    a_r7_step_one: assert property (@(posedge clk[0]) disable iff (|rst)
      !clr[d] |=> (err_cnt[d] == $past(err_cnt[d]) ||
                   err_cnt[d] == $past(err_cnt[d]) + 1'b1));

    a_r8_saturated: assert property (@(posedge clk[0]) disable iff (|rst)
      (err_cnt[d] == '1 && !clr[d]) |=> err_cnt[d] == '1);

    a_r9_clear: assert property (@(posedge clk[0]) disable iff (|rst)
      clr[d] |=> err_cnt[d] == '0);
  end

endmodule

bind tmr_vote_stage tmr_vote_stage_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ld(ld), .acc(acc), .clr(clr), .q(q), .oe(oe),
  .err_cnt(err_cnt), .disabled(disabled), .uncorrectable(uncorrectable)
);

// File: tb/tmr_vote_stage_test.sv
module tmr_vote_stage_test;
  localparam int W = 8;
  localparam int CW = 4;

  logic c = 1'b0;
  always #4 c = ~c;

  logic [2:0]         clk;
  logic [2:0]         rst, ld, acc, clr;
  logic [2:0][W-1:0]  din;
  logic [2:0][W-1:0]  q;
  logic [2:0]         oe, disabled;
  logic [2:0][CW-1:0] err_cnt;
  logic               uncorrectable;

  assign clk = {3{c}};

  tmr_vote_stage #(.W(W), .CW(CW), .RST_VAL(8'h5A)) uut (
    .clk(clk), .rst(rst), .ld(ld), .acc(acc), .clr(clr), .din(din),
    .q(q), .oe(oe), .err_cnt(err_cnt), .disabled(disabled),
    .uncorrectable(uncorrectable)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {ld, acc, din, expected q}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 1'b0, 8'h10, 8'h10},
    {1'b0, 1'b1, 8'h05, 8'h15},
    {1'b0, 1'b1, 8'hF0, 8'h05},
    {1'b0, 1'b0, 8'h33, 8'h05},
    {1'b1, 1'b1, 8'h77, 8'h77},
    {1'b0, 1'b1, 8'h01, 8'h78},
    {1'b0, 1'b1, 8'h88, 8'h00},
    {1'b0, 1'b0, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] l, input logic [2:0] a, input logic [2:0] k,
                      input logic [W-1:0] d0, input logic [W-1:0] d1, input logic [W-1:0] d2);
    ld = l; acc = a; clr = k; din[0] = d0; din[1] = d1; din[2] = d2;
    @(posedge c);
    @(negedge c);
  endtask

  initial begin
    rst = 3'b111; ld = '0; acc = '0; clr = '0; din = '0;
    @(posedge c); @(posedge c); @(negedge c);
    rst = 3'b000;

    // R1 reset state
    for (int d = 0; d < 3; d++) chk("R1 q after reset", 32'(q[d]), 32'h5A);
    chk("R1 counters after reset", 32'(err_cnt), 32'h0);
    chk("R5 nothing disabled after reset", 32'(disabled), 32'h0);

    // R2 table of normal operation with identical domains
    for (int i = 0; i < 8; i++) begin
      step({3{VEC[i][17]}}, {3{VEC[i][16]}}, 3'b000, VEC[i][15:8], VEC[i][15:8], VEC[i][15:8]);
      for (int d = 0; d < 3; d++) chk($sformatf("R2 vector %0d q", i), 32'(q[d]), 32'(VEC[i][7:0]));
      chk($sformatf("R4 vector %0d oe", i), 32'(oe), 32'h7);
      chk($sformatf("R6 vector %0d flag", i), 32'(uncorrectable), 32'h0);
    end

    // R4/R5 single divergent domain through load
    step(3'b111, 3'b000, 3'b000, 8'h3C, 8'hA7, 8'h3C);
    chk("R4 oe with domain 1 diverged", 32'(oe), 32'h5);
    chk("R4 q0 healthy", 32'(q[0]), 32'h3C);
    chk("R4 q2 healthy", 32'(q[2]), 32'h3C);
    chk("R4 q1 forced zero", 32'(q[1]), 32'h0);
    chk("R5 disabled bit 1", 32'(disabled), 32'h2);
    chk("R6 single fault not flagged", 32'(uncorrectable), 32'h0);

    // R3 repair through voted feedback, R7 count
    step(3'b000, 3'b000, 3'b000, 8'h00, 8'h00, 8'h00);
    chk("R3 domain 1 repaired", 32'(q[1]), 32'h3C);
    chk("R3 all enabled", 32'(oe), 32'h7);
    chk("R7 cnt1 after one mismatch", 32'(err_cnt[1]), 32'h1);
    chk("R7 cnt0 untouched", 32'(err_cnt[0]), 32'h0);
    chk("R7 cnt2 untouched", 32'(err_cnt[2]), 32'h0);

    // R2 accumulate with a faulty addend in domain 1
    step(3'b000, 3'b111, 3'b000, 8'h01, 8'h40, 8'h01);
    chk("R2 accumulate q0", 32'(q[0]), 32'h3D);
    chk("R5 accumulate fault disables 1", 32'(disabled), 32'h2);
    step(3'b000, 3'b000, 3'b000, 8'h00, 8'h00, 8'h00);
    chk("R3 accumulate fault repaired", 32'(q[1]), 32'h3D);
    chk("R7 cnt1 second mismatch", 32'(err_cnt[1]), 32'h2);

    // R10/R6 double fault: bitwise majority of 11,22,33 is 33
    step(3'b111, 3'b000, 3'b000, 8'h11, 8'h22, 8'h33);
    chk("R6 double fault flagged", 32'(uncorrectable), 32'h1);
    chk("R10 only domain 2 enabled", 32'(oe), 32'h4);
    chk("R10 surviving value", 32'(q[2]), 32'h33);
    chk("R4 q0 zero while disabled", 32'(q[0]), 32'h0);
    step(3'b000, 3'b000, 3'b000, 8'h00, 8'h00, 8'h00);
    chk("R10 all take majority", 32'(q), {8'h33, 8'h33, 8'h33});
    chk("R6 flag clears", 32'(uncorrectable), 32'h0);
    chk("R7 cnt0 after double", 32'(err_cnt[0]), 32'h1);
    chk("R7 cnt1 after double", 32'(err_cnt[1]), 32'h3);

    // R8 saturation of domain 2
    for (int i = 0; i < 17; i++) step(3'b111, 3'b000, 3'b000, 8'h44, 8'h44, 8'h99);
    chk("R8 cnt2 saturated", 32'(err_cnt[2]), 32'hF);
    step(3'b111, 3'b000, 3'b000, 8'h44, 8'h44, 8'h99);
    chk("R8 cnt2 stays saturated", 32'(err_cnt[2]), 32'hF);

    // R9 clear only domain 2, beating a pending increment
    step(3'b111, 3'b000, 3'b100, 8'h44, 8'h44, 8'h99);
    chk("R9 cnt2 cleared", 32'(err_cnt[2]), 32'h0);
    chk("R9 cnt1 kept", 32'(err_cnt[1]), 32'h3);
    chk("R9 cnt0 kept", 32'(err_cnt[0]), 32'h1);

    // R1 reset again restores value and counters
    rst = 3'b111; step(3'b000, 3'b000, 3'b000, 8'h00, 8'h00, 8'h00); rst = 3'b000;
    chk("R1 value after second reset", 32'(q), {8'h5A, 8'h5A, 8'h5A});
    chk("R1 counters after second reset", 32'(err_cnt), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule